// File: doc/BRIEF.md
# Coprocessor Bus Address Decoder

This block sits between a coprocessor core and its byte-wide memories. For every access it reads a 24-bit address and picks one target from six: the register file, ROM behind the mapping controller, the banked work-RAM window (also handled by the mapping controller), linear work RAM, a 2 KB internal RAM, and a bitmap RAM. Each region is found by masking the address and comparing it with a fixed pattern. The checks run in a fixed priority order and the first one that matches wins. The block then drives a one-hot target select and a local offset, and holds both for the whole access.

The core uses a request/ready handshake. The decoder stretches each access with wait states that depend on the address. Most regions take two clocks. The banked window, and any bank whose address matches the slow-bank pattern, take four clocks. A read from an address that matches no region returns zero. A write to such an address is dropped. A write to ROM is also dropped. A separate combinational check tells the DMA engine whether the region kinds it has marked for a transfer byte are allowed, given the source and destination addresses.

Top module: `cbd_addr_decoder`

## Requirements
- R1: An address with (addr & 0x40FE00) == 0x002200 selects the register file, which is `tgt_sel` bit 0. The offset is addr & 0x1FF. This test has the highest priority.
- R2: An address with (addr & 0x408000) == 0x008000, or with (addr & 0xC00000) == 0xC00000, selects ROM, which is `tgt_sel` bit 1. The offset is the full address. A write that decodes to ROM drives no select and no `tgt_we`, and it completes with the normal latency.
- R3: An address with (addr & 0x40E000) == 0x006000 selects the banked work-RAM window, which is `tgt_sel` bit 2. The offset is the full address.
- R4: An address with (addr & 0x40F800) equal to 0x000000 or 0x003000 selects internal RAM, which is `tgt_sel` bit 3. The offset is addr & 0x7FF.
- R5: Banks 0x40-0x4F select linear work RAM (`tgt_sel` bit 4) with offset addr & (2^LW_AW - 1). Banks 0x60-0x6F select bitmap RAM (`tgt_sel` bit 5) with offset addr & (2^BMP_AW - 1).
- R6: The regions are tested in the order R1, R2, R3, R4, R5. The first match wins, so at most one `tgt_sel` bit is high at any time.
- R7: An access takes BASE_WAIT clocks, which is 2 by default. It takes BASE_WAIT + EXTRA_WAIT clocks, 4 by default, when the R3 match holds or when (addr & 0xD00000) == 0x400000. This means bitmap RAM is also slow.
- R8: An address that matches no region drives no select and no write strobe. A read from it returns 0x00. It completes in BASE_WAIT clocks.
- R9: `dma_ok` is 1 only when both addresses are allowed. The source must match a ROM pattern from R2 when `dma_src_kind` is 0, or a work-RAM pattern (R3 or linear work RAM) when `dma_src_kind` is 1. The destination must match a work-RAM pattern.
- R10: A request is taken when `req` is high and no access is in flight. `ready` then rises the stated number of clock edges later, stays high for exactly one cycle, and is low before that. `tgt_sel`, `tgt_off` and `tgt_we` hold steady while the access is in flight. `rd_data` carries `tgt_rdata` only in the ready cycle of a mapped read, and is 0 otherwise.
- R11: While reset is active, and until a request arrives after it, `ready`, `tgt_sel`, `tgt_we` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Access request, held until ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Access address, held while the request is pending |
| tgt_rdata | input | 8 | Read byte returned by the selected target |
| ready | output | 1 | Access complete; read data is valid in this cycle |
| rd_data | output | 8 | Read byte returned to the core |
| tgt_sel | output | 6 | One-hot target select |
| tgt_off | output | 24 | Local offset within the selected target |
| tgt_we | output | 1 | Write strobe to the selected target |
| dma_src_addr | input | 24 | DMA source address |
| dma_src_kind | input | 1 | Source kind: 0 ROM, 1 work RAM |
| dma_dst_addr | input | 24 | DMA destination address (work RAM) |
| dma_ok | output | 1 | DMA transfer byte is allowed |

## Verification
The bench builds the decoder with LW_AW = 12 and BMP_AW = 10, instead of the full-size defaults. With these small sizes, an address deep inside a bank folds to a short offset that is easy to see, so the R5 masking is actually exercised. It keeps BASE_WAIT = 2 and EXTRA_WAIT = 2. This lets the bench check, on every clock, both wait lengths against its own model. It also covers the slow-bank pattern, including bitmap banks and unmapped banks next to them.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int ADDR_W  = 24;
  localparam int NUM_TGT = 6;

  // select bit index = region code - 1
  typedef enum logic [2:0] {
    RG_NONE  = 3'd0,
    RG_REGS  = 3'd1,
    RG_ROM   = 3'd2,
    RG_BWIN  = 3'd3,
    RG_IRAM  = 3'd4,
    RG_LWRAM = 3'd5,
    RG_BMP   = 3'd6
  } region_e;

  function automatic logic hit_rom(input logic [ADDR_W-1:0] a);
    return ((a & 24'h408000) == 24'h008000) || ((a & 24'hC00000) == 24'hC00000);
  endfunction

  function automatic logic hit_bwin(input logic [ADDR_W-1:0] a);
    return (a & 24'h40E000) == 24'h006000;
  endfunction

  function automatic logic hit_lwram(input logic [ADDR_W-1:0] a);
    return (a & 24'hF00000) == 24'h400000;
  endfunction

  function automatic logic hit_wram(input logic [ADDR_W-1:0] a);
    return hit_bwin(a) || hit_lwram(a);
  endfunction
endpackage

// File: rtl/cbd_region_decode.sv
module cbd_region_decode
  import cbd_pkg::*;
#(
  parameter int LW_AW  = 18,
  parameter int BMP_AW = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output region_e           region,
  output logic [ADDR_W-1:0] off,
  output logic              slow
);
  localparam logic [ADDR_W-1:0] LW_MASK  = ADDR_W'((64'd1 << LW_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] BMP_MASK = ADDR_W'((64'd1 << BMP_AW) - 64'd1);

  logic m_regs, m_rom, m_bwin, m_iram, m_lw, m_bmp;

  always_comb begin
    m_regs = (addr & 24'h40FE00) == 24'h002200;
    m_rom  = hit_rom(addr);
    m_bwin = hit_bwin(addr);
    m_iram = ((addr & 24'h40F800) == 24'h000000) || ((addr & 24'h40F800) == 24'h003000);
    m_lw   = hit_lwram(addr);
    m_bmp  = (addr & 24'hF00000) == 24'h600000;
  end

  // fixed priority; a ROM write is dropped rather than passed on
  always_comb begin
    region = RG_NONE;
    off    = '0;
    if (m_regs) begin
      region = RG_REGS;
      off    = {15'd0, addr[8:0]};
    end else if (m_rom) begin
      region = we ? RG_NONE : RG_ROM;
      off    = we ? '0 : addr;
    end else if (m_bwin) begin
      region = RG_BWIN;
      off    = addr;
    end else if (m_iram) begin
      region = RG_IRAM;
      off    = {13'd0, addr[10:0]};
    end else if (m_lw) begin
      region = RG_LWRAM;
      off    = addr & LW_MASK;
    end else if (m_bmp) begin
      region = RG_BMP;
      off    = addr & BMP_MASK;
    end
  end

  assign slow = m_bwin || ((addr & 24'hD00000) == 24'h400000);
endmodule

// File: rtl/cbd_wait_ctl.sv
module cbd_wait_ctl #(
  parameter int BASE_WAIT  = 2,
  parameter int EXTRA_WAIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic slow,
  output logic accept,
  output logic busy,
  output logic ready
);
  localparam int CNT_W = $clog2(BASE_WAIT + EXTRA_WAIT + 1);
  localparam logic [CNT_W-1:0] FAST_LOAD = CNT_W'(BASE_WAIT - 1);
  localparam logic [CNT_W-1:0] SLOW_LOAD = CNT_W'(BASE_WAIT + EXTRA_WAIT - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    accept = req && !busy_q;
    ready  = busy_q && (cnt_q == '0);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = slow ? SLOW_LOAD : FAST_LOAD;
    end else if (ready) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/cbd_dma_gate.sv
module cbd_dma_gate
  import cbd_pkg::*;
(
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              src_kind,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              ok
);
  logic src_ok;

  always_comb begin
    src_ok = src_kind ? hit_wram(src_addr) : hit_rom(src_addr);
    ok     = src_ok && hit_wram(dst_addr);
  end
endmodule

// File: rtl/cbd_addr_decoder.sv
module cbd_addr_decoder
  import cbd_pkg::*;
#(
  parameter int LW_AW      = 18,
  parameter int BMP_AW     = 17,
  parameter int BASE_WAIT  = 2,
  parameter int EXTRA_WAIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        req_we,
  input  logic [23:0] req_addr,
  input  logic [7:0]  tgt_rdata,
  output logic        ready,
  output logic [7:0]  rd_data,
  output logic [5:0]  tgt_sel,
  output logic [23:0] tgt_off,
  output logic        tgt_we,
  input  logic [23:0] dma_src_addr,
  input  logic        dma_src_kind,
  input  logic [23:0] dma_dst_addr,
  output logic        dma_ok
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  region_e           region_d, region_q;
  logic [ADDR_W-1:0] off_d, off_q;
  logic              we_q;
  logic              slow;
  logic              accept, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cbd_region_decode #(.LW_AW(LW_AW), .BMP_AW(BMP_AW)) u_dec (
    .addr(req_addr), .we(req_we), .region(region_d), .off(off_d), .slow(slow)
  );

  cbd_wait_ctl #(.BASE_WAIT(BASE_WAIT), .EXTRA_WAIT(EXTRA_WAIT)) u_wait (
    .clk(clk), .rst_n(rst_int_n), .req(req), .slow(slow),
    .accept(accept), .busy(busy), .ready(ready)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      region_q <= RG_NONE;
      off_q    <= '0;
      we_q     <= 1'b0;
    end else if (accept) begin
      region_q <= region_d;
      off_q    <= off_d;
      we_q     <= req_we;
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
    assign tgt_sel[g] = busy && (region_q == region_e'(3'(g + 1)));
  end

  assign tgt_off = off_q;
  assign tgt_we  = busy && we_q && (region_q != RG_NONE);
  assign rd_data = (ready && !we_q && (region_q != RG_NONE)) ? tgt_rdata : 8'h00;

  cbd_dma_gate u_dma (
    .src_addr(dma_src_addr), .src_kind(dma_src_kind), .dst_addr(dma_dst_addr), .ok(dma_ok)
  );
endmodule

// File: rtl/cbd_addr_decoder_chk.sv
module cbd_addr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ready,
  input logic        busy,
  input logic        lat_we,
  input logic [5:0]  tgt_sel,
  input logic [23:0] tgt_off,
  input logic        tgt_we,
  input logic [7:0]  rd_data
);
  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  assert_ready_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready) |=> ($stable(tgt_sel) && $stable(tgt_off) && $stable(tgt_we)));

  assert_rom_write_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lat_we) |-> !tgt_sel[1]);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (tgt_sel == 6'd0)) |-> (rd_data == 8'h00));

  assert_iram_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel[3] |-> (tgt_off[23:11] == 13'd0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ready && (tgt_sel == 6'd0) && !tgt_we));
endmodule

bind cbd_addr_decoder cbd_addr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .busy(busy), .lat_we(we_q),
  .tgt_sel(tgt_sel), .tgt_off(tgt_off), .tgt_we(tgt_we), .rd_data(rd_data)
);

// File: tb/cbd_addr_decoder_bench.sv
module cbd_addr_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW_AW  = 12;
  localparam int BMP_AW = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_we;
  logic [23:0] req_addr;
  logic [7:0]  tgt_rdata;
  logic        ready;
  logic [7:0]  rd_data;
  logic [5:0]  tgt_sel;
  logic [23:0] tgt_off;
  logic        tgt_we;
  logic [23:0] dma_src_addr, dma_dst_addr;
  logic        dma_src_kind;
  logic        dma_ok;

  int    total = 0;
  int    bad   = 0;
  string cur_tag = "R11";
  logic  cmp_on = 1'b0;

  // reference model state
  logic        m_busy;
  int          m_left;
  logic [23:0] m_addr;
  logic        m_we;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbd_addr_decoder #(.LW_AW(LW_AW), .BMP_AW(BMP_AW)) u_cbd_addr_decoder (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .tgt_rdata(tgt_rdata), .ready(ready), .rd_data(rd_data), .tgt_sel(tgt_sel),
    .tgt_off(tgt_off), .tgt_we(tgt_we), .dma_src_addr(dma_src_addr),
    .dma_src_kind(dma_src_kind), .dma_dst_addr(dma_dst_addr), .dma_ok(dma_ok)
  );

  function automatic int exp_region(input logic [23:0] a, input logic we);
    if ((a & 24'h40FE00) == 24'h002200) return 1;
    if (((a & 24'h408000) == 24'h008000) || ((a & 24'hC00000) == 24'hC00000)) return we ? 0 : 2;
    if ((a & 24'h40E000) == 24'h006000) return 3;
    if ((a & 24'h40F800) == 24'h000000 || (a & 24'h40F800) == 24'h003000) return 4;
    if ((a & 24'hF00000) == 24'h400000) return 5;
    if ((a & 24'hF00000) == 24'h600000) return 6;
    return 0;
  endfunction

  function automatic logic [23:0] exp_off(input logic [23:0] a, input logic we);
    case (exp_region(a, we))
      1: return a % 24'h200;
      2, 3: return a;
      4: return a % 24'h800;
      5: return a % (24'd1 << LW_AW);
      6: return a % (24'd1 << BMP_AW);
      default: return 24'h0;
    endcase
  endfunction

  function automatic int exp_wait(input logic [23:0] a);
    if (((a & 24'h40E000) == 24'h006000) || ((a & 24'hD00000) == 24'h400000)) return 4;
    return 2;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // model steps on the same edges as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_left <= 0; m_addr <= '0; m_we <= 1'b0;
    end else if (!m_busy && req) begin
      m_busy <= 1'b1; m_left <= exp_wait(req_addr) - 1; m_addr <= req_addr; m_we <= req_we;
    end else if (m_busy && m_left == 0) begin
      m_busy <= 1'b0;
    end else if (m_busy) begin
      m_left <= m_left - 1;
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      int rg;
      logic [5:0] es;
      logic ew, er;
      rg = m_busy ? exp_region(m_addr, m_we) : 0;
      es = (rg == 0) ? 6'd0 : 6'(1 << (rg - 1));
      er = m_busy && (m_left == 0);
      ew = m_busy && m_we && (rg != 0);
      check("R10", ready, er, "ready");
      check(cur_tag, tgt_sel, es, "sel");
      check(cur_tag, tgt_we, ew, "we");
      if (m_busy) check(cur_tag, tgt_off, exp_off(m_addr, m_we), "offset");
      check("R10", rd_data, (er && !m_we && rg != 0) ? tgt_rdata : 8'h00, "rd_data");
    end
  end

  task automatic access(input logic [23:0] a, input logic we, input string tag);
    int lat = 0;
    @(negedge clk);
    cur_tag = tag; req = 1'b1; req_we = we; req_addr = a;
    tgt_rdata = a[7:0] ^ 8'h5A;
    while (1) begin
      @(negedge clk);
      lat++;
      if (ready || lat > 20) break;
    end
    check("R7", lat, exp_wait(a), "latency");
    if (!we) check(tag, rd_data, (exp_region(a, 1'b0) != 0) ? (a[7:0] ^ 8'h5A) : 8'h00, "read data");
    req = 1'b0;
  endtask

  task automatic dma(input logic [23:0] s, input logic k, input logic [23:0] d, input logic exp);
    dma_src_addr = s; dma_src_kind = k; dma_dst_addr = d;
    #1;
    check("R9", dma_ok, exp, "dma_ok");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; tgt_rdata = '0;
    dma_src_addr = '0; dma_src_kind = 1'b0; dma_dst_addr = '0;
    repeat (3) @(negedge clk);
    check("R11", ready, 1'b0, "reset ready");
    check("R11", tgt_sel, 6'd0, "reset sel");
    check("R11", rd_data, 8'h00, "reset rd_data");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;

    access(24'h002200, 1'b0, "R1");
    access(24'h8023FF, 1'b1, "R1");
    access(24'h008000, 1'b0, "R2");
    access(24'hC01234, 1'b0, "R2");
    access(24'h00FFFF, 1'b1, "R2");
    access(24'hFF0010, 1'b1, "R2");
    access(24'h006000, 1'b0, "R3");
    access(24'h817FFF, 1'b1, "R3");
    access(24'h000123, 1'b0, "R4");
    access(24'h0037FF, 1'b1, "R4");
    access(24'h803456, 1'b0, "R4");
    access(24'h40ABCD, 1'b0, "R5");
    access(24'h4F0FFF, 1'b1, "R5");
    access(24'h6F1234, 1'b0, "R5");
    access(24'h600000, 1'b1, "R7");
    access(24'h5F0000, 1'b0, "R7");
    access(24'h201000, 1'b0, "R8");
    access(24'h700000, 1'b1, "R8");
    access(24'h3F2200, 1'b0, "R6");
    access(24'h3F8000, 1'b0, "R6");

    dma(24'h008000, 1'b0, 24'h006000, 1'b1);
    dma(24'h400000, 1'b0, 24'h006000, 1'b0);
    dma(24'h4F0000, 1'b1, 24'h412345, 1'b1);
    dma(24'h4F0000, 1'b1, 24'h002200, 1'b0);
    dma(24'hC00000, 1'b1, 24'h400000, 1'b0);
    dma(24'hC00000, 1'b0, 24'h807FFF, 1'b1);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule